// File: doc/BRIEF.md
# Transport-Layer Sample Deframer for a Two-Path Upconverting DAC

This block sits behind the lane receivers of a serial converter link. It takes aligned, descrambled octets from up to eight lanes and rebuilds complex I/Q samples for one or two DAC paths. Each DAC path carries one or two upconverter channels. The incoming octets share one valid strobe and one frame-start marker. A 4-bit mode input picks the lane-to-sample layout. The layout fixes the frame length F (1, 2, 3 or 4 octets per lane), the lane each sample half travels on, and whether samples are 16-bit or packed 12-bit.

The outputs are four sample slots, each with an I word and a Q word. Slots 0 and 1 belong to DAC A and slots 2 and 3 to DAC B. Within a DAC, the lower slot is upconverter channel 1 and the upper slot is channel 2. In the two-samples-per-frame layout, slots 0 and 1 instead hold the time-0 and time-1 samples of DAC A. Every slot updates in the same cycle, which is marked by a one-cycle valid pulse.

Top module: `jesd_deframer`

## Requirements
- R1: Reset sets `smp_vld` low and every slot to zero. Until the first octet marked with `frame_start`, valid octets produce no sample.
- R2: The octet position is zero on a valid octet with `frame_start`. It advances only on valid octets and wraps after F−1. F is 1 for modes 0–2, 2 for modes 3–6, 4 for modes 7–10 and 3 for modes 11–12.
- R3: `smp_vld` is high for one cycle, in the cycle after the clock edge that takes the last octet of a frame. Slot outputs change only at that edge.
- R4: On every layout, the octet holding sample bits 15:8 comes earlier in the frame, or on a lower lane, than the octet holding bits 7:0.
- R5: Mode 0 (8 lanes, F=1, two samples per frame). Lanes 0..3 carry slot0 I high, slot0 I low, slot1 I high and slot1 I low. Lanes 4..7 carry the same order for Q.
- R6: Mode 1 (4 lanes, F=1): lanes 0..3 carry slot0 I high, I low, Q high and Q low. Mode 2 (8 lanes, F=1, dual DAC) adds the same pattern on lanes 4..7 for slot 2.
- R7: In the F=2 modes, lane 2p carries an I sample and lane 2p+1 its Q sample, high octet first. Mode 3 uses pair 0 for slot 0. Mode 4 uses pairs 0 and 1 for slots 0 and 2. Mode 5 uses pairs 0 and 1 for slots 0 and 1. Mode 6 uses pairs 0..3 for slots 0..3.
- R8: In the F=4 modes, a lane carries I high, I low, Q high and Q low in that order. Mode 7 uses lane 0 for slot 0. Mode 8 uses lanes 0 and 1 for slots 0 and 2. Mode 9 uses lanes 0 and 1 for slots 0 and 1. Mode 10 uses lanes 0..3 for slots 0..3.
- R9: In the F=3 modes, a lane's 24 bits, high octet first, hold a 12-bit I followed by a 12-bit Q. Each is output left-justified in 16 bits with bits 3:0 zero. Mode 11 uses lanes 0 and 1 for slots 0 and 1. Mode 12 uses lanes 0..3 for slots 0..3.
- R10: Slots that the active mode does not fill read zero. Octets on lanes the mode does not use have no effect on any output.
- R11: `mode_sel` is taken only with a valid octet carrying `frame_start`. Changes to it at any other time do not affect the frame in progress.
- R12: A `frame_start` in the middle of a frame discards the partial frame and begins a new one with no sample emitted for the partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| oct_vld | input | 1 | All lane octets valid this cycle |
| frame_start | input | 1 | Current valid octet is octet 0 of a frame |
| mode_sel | input | 4 | Layout code 0..12 (see R2, R5–R9) |
| lane_oct | input | 8x8 | Octet of each lane, lane n at [n] |
| smp_vld | output | 1 | One-cycle pulse: new samples on all slots |
| smp_i | output | 4x16 | I sample of each slot |
| smp_q | output | 4x16 | Q sample of each slot |

## Verification
The assertions check on every cycle the behaviours that hold no matter which frames are sent. The octet position stays below the active frame length, and the latched mode moves only on a frame start. A sample pulse always follows a valid octet, the outputs hold between pulses, and packed samples leave their low nibbles clear. The lane-to-slot layouts themselves can be shown only by the bench scenarios. These include the byte ordering of each mode and the zeroing of unused slots. They also include immunity to garbage on idle lanes and to mode changes mid-frame, and the discarding of a restarted partial frame. The bench packs random samples with its own packer and compares the held outputs against its model after every clock.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  localparam int OCT_W     = 8;
  localparam int SMP_W     = 2 * OCT_W;
  localparam int LANES     = 8;
  localparam int SLOTS     = 4;
  localparam int MAX_F     = 4;
  localparam int WORD_W    = MAX_F * OCT_W;
  localparam int POS_W     = $clog2(MAX_F);
  localparam int PACK_W    = 12;

  typedef enum logic [3:0] {
    M_L8F1_2T    = 4'd0,
    M_L4F1       = 4'd1,
    M_L8F1_DUAL  = 4'd2,
    M_L2F2       = 4'd3,
    M_L4F2_DUAL  = 4'd4,
    M_L4F2_M4    = 4'd5,
    M_L8F2_M4    = 4'd6,
    M_L1F4       = 4'd7,
    M_L2F4_DUAL  = 4'd8,
    M_L2F4_M4    = 4'd9,
    M_L4F4_M4    = 4'd10,
    M_L2F3_M4    = 4'd11,
    M_L4F3_M4    = 4'd12
  } mode_t;

  // Octets per lane per frame for each layout.
  function automatic logic [POS_W:0] frame_len(input mode_t m);
    case (m)
      M_L2F2, M_L4F2_DUAL, M_L4F2_M4, M_L8F2_M4:   frame_len = 3'd2;
      M_L1F4, M_L2F4_DUAL, M_L2F4_M4, M_L4F4_M4:   frame_len = 3'd4;
      M_L2F3_M4, M_L4F3_M4:                        frame_len = 3'd3;
      default:                                     frame_len = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/dfr_frame_ctr.sv
module dfr_frame_ctr
  import dfr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  oct_vld,
  input  logic  frame_start,
  input  mode_t mode_in,
  output mode_t eff_mode,
  output logic  frame_last
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_now;
  logic [POS_W:0]   len_now;
  mode_t            act_mode;
  logic             synced;
  logic             in_frame;

  // A start marker applies its own mode to the octet it travels with.
  assign eff_mode = frame_start ? mode_in : act_mode;
  assign len_now  = frame_len(eff_mode);
  assign pos_now  = frame_start ? '0 : pos_q;
  assign in_frame = frame_start | synced;
  assign frame_last = oct_vld && in_frame &&
                      ({1'b0, pos_now} == len_now - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      act_mode <= M_L8F1_2T;
      synced   <= 1'b0;
    end else if (oct_vld) begin
      if (frame_start) begin
        act_mode <= mode_in;
        synced   <= 1'b1;
      end
      if (in_frame)
        pos_q <= frame_last ? '0 : pos_now + 1'b1;
    end
  end

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    synced |-> ({1'b0, pos_q} < frame_len(act_mode))); // R2

  AST_MODE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !(oct_vld && frame_start) |=> $stable(act_mode)); // R11

endmodule

// File: rtl/dfr_lane_hist.sv
module dfr_lane_hist
  import dfr_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int DEPTH   = MAX_F
)(
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                oct_vld,
  input  logic [N_LANES-1:0][OCT_W-1:0]       lane_oct,
  output logic [N_LANES-1:0][DEPTH*OCT_W-1:0] frame_word
);

  localparam int HIST_W = (DEPTH - 1) * OCT_W;

  // Each lane keeps its last DEPTH-1 octets; with the live octet they form
  // a right-aligned word whose oldest octet sits highest.
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [HIST_W-1:0] hist;

    always_ff @(posedge clk) begin
      if (rst)
        hist <= '0;
      else if (oct_vld)
        hist <= {hist[HIST_W-OCT_W-1:0], lane_oct[l]};
    end

    assign frame_word[l] = {hist, lane_oct[l]};
  end

endmodule

// File: rtl/dfr_slot_map.sv
module dfr_slot_map
  import dfr_pkg::*;
(
  input  mode_t                         mode,
  input  logic [LANES-1:0][WORD_W-1:0]  w,
  output logic [SLOTS-1:0][SMP_W-1:0]   si,
  output logic [SLOTS-1:0][SMP_W-1:0]   sq
);

  localparam int PAD_W = SMP_W - PACK_W;

  always_comb begin
    si = '0;
    sq = '0;
    case (mode)
      M_L8F1_2T: begin
        si[0] = {w[0][7:0], w[1][7:0]};
        si[1] = {w[2][7:0], w[3][7:0]};
        sq[0] = {w[4][7:0], w[5][7:0]};
        sq[1] = {w[6][7:0], w[7][7:0]};
      end
      M_L4F1, M_L8F1_DUAL: begin
        si[0] = {w[0][7:0], w[1][7:0]};
        sq[0] = {w[2][7:0], w[3][7:0]};
        if (mode == M_L8F1_DUAL) begin
          si[2] = {w[4][7:0], w[5][7:0]};
          sq[2] = {w[6][7:0], w[7][7:0]};
        end
      end
      M_L2F2: begin
        si[0] = w[0][SMP_W-1:0];
        sq[0] = w[1][SMP_W-1:0];
      end
      M_L4F2_DUAL: begin
        si[0] = w[0][SMP_W-1:0];
        sq[0] = w[1][SMP_W-1:0];
        si[2] = w[2][SMP_W-1:0];
        sq[2] = w[3][SMP_W-1:0];
      end
      M_L4F2_M4, M_L8F2_M4: begin
        for (int p = 0; p < SLOTS; p++) begin
          if (p < 2 || mode == M_L8F2_M4) begin
            si[p] = w[2*p][SMP_W-1:0];
            sq[p] = w[2*p+1][SMP_W-1:0];
          end
        end
      end
      M_L1F4, M_L2F4_DUAL, M_L2F4_M4, M_L4F4_M4: begin
        si[0] = w[0][WORD_W-1:SMP_W];
        sq[0] = w[0][SMP_W-1:0];
        if (mode == M_L2F4_DUAL) begin
          si[2] = w[1][WORD_W-1:SMP_W];
          sq[2] = w[1][SMP_W-1:0];
        end else if (mode != M_L1F4) begin
          for (int l = 1; l < SLOTS; l++) begin
            if (l < 2 || mode == M_L4F4_M4) begin
              si[l] = w[l][WORD_W-1:SMP_W];
              sq[l] = w[l][SMP_W-1:0];
            end
          end
        end
      end
      M_L2F3_M4, M_L4F3_M4: begin
        for (int l = 0; l < SLOTS; l++) begin
          if (l < 2 || mode == M_L4F3_M4) begin
            si[l] = {w[l][2*PACK_W-1:PACK_W], {PAD_W{1'b0}}};
            sq[l] = {w[l][PACK_W-1:0],        {PAD_W{1'b0}}};
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/jesd_deframer.sv
module jesd_deframer
  import dfr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          oct_vld,
  input  logic                          frame_start,
  input  logic [3:0]                    mode_sel,
  input  logic [LANES-1:0][OCT_W-1:0]   lane_oct,
  output logic                          smp_vld,
  output logic [SLOTS-1:0][SMP_W-1:0]   smp_i,
  output logic [SLOTS-1:0][SMP_W-1:0]   smp_q
);

  mode_t                        eff_mode;
  logic                         frame_last;
  logic [LANES-1:0][WORD_W-1:0] frame_word;
  logic [SLOTS-1:0][SMP_W-1:0]  map_i;
  logic [SLOTS-1:0][SMP_W-1:0]  map_q;

  dfr_frame_ctr u_ctr (
    .clk         (clk),
    .rst         (rst),
    .oct_vld     (oct_vld),
    .frame_start (frame_start),
    .mode_in     (mode_t'(mode_sel)),
    .eff_mode    (eff_mode),
    .frame_last  (frame_last)
  );

  dfr_lane_hist #(.N_LANES(LANES), .DEPTH(MAX_F)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .oct_vld    (oct_vld),
    .lane_oct   (lane_oct),
    .frame_word (frame_word)
  );

  dfr_slot_map u_map (
    .mode (eff_mode),
    .w    (frame_word),
    .si   (map_i),
    .sq   (map_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_vld <= 1'b0;
      smp_i   <= '0;
      smp_q   <= '0;
    end else begin
      smp_vld <= frame_last;
      if (frame_last) begin
        smp_i <= map_i;
        smp_q <= map_q;
      end
    end
  end

  AST_PULSE_FOLLOWS_OCTET: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(oct_vld)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |-> ($stable(smp_i) && $stable(smp_q))); // R3

  AST_PACKED_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $past(eff_mode == M_L2F3_M4 || eff_mode == M_L4F3_M4)) |->
      (smp_i[0][3:0] == 4'd0 && smp_q[0][3:0] == 4'd0 &&
       smp_i[1][3:0] == 4'd0 && smp_q[1][3:0] == 4'd0)); // R9

endmodule

// File: tb/jesd_deframer_test.sv
module jesd_deframer_test;

  logic            clk = 1'b0;
  logic            rst;
  logic            oct_vld;
  logic            frame_start;
  logic [3:0]      mode_sel;
  logic [7:0][7:0] lane_oct;
  logic            smp_vld;
  logic [3:0][15:0] smp_i;
  logic [3:0][15:0] smp_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural model state
  logic [15:0] hold_i [4];
  logic [15:0] hold_q [4];
  logic [15:0] ti [4];
  logic [15:0] tq [4];
  logic [7:0]  lb [8][4];

  always #4 clk = ~clk;

  jesd_deframer uut (
    .clk(clk), .rst(rst), .oct_vld(oct_vld), .frame_start(frame_start),
    .mode_sel(mode_sel), .lane_oct(lane_oct),
    .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q)
  );

  function automatic int flen(int m);
    if (m <= 2) return 1;
    if (m <= 6) return 2;
    if (m <= 10) return 4;
    return 3;
  endfunction

  function automatic string mtag(int m);
    if (m == 0) return "R5 R4";
    if (m <= 2) return "R6 R4";
    if (m <= 6) return "R7 R4";
    if (m <= 10) return "R8 R4";
    return "R9";
  endfunction

  task automatic check_outputs(bit exp_vld, string tag);
    n_chk++;
    if (smp_vld !== exp_vld) begin
      n_bad++;
      $display("FAIL R3 %s: smp_vld=%0b expected %0b", tag, smp_vld, exp_vld);
    end
    for (int s = 0; s < 4; s++) begin
      n_chk++;
      if (smp_i[s] !== hold_i[s] || smp_q[s] !== hold_q[s]) begin
        n_bad++;
        $display("FAIL %s slot%0d: I=%h Q=%h expected I=%h Q=%h",
                 tag, s, smp_i[s], smp_q[s], hold_i[s], hold_q[s]);
      end
    end
  endtask

  // One clock: drive at the falling edge, compare after the rising edge.
  task automatic step(bit v, bit st, int m, bit completes, string tag);
    @(negedge clk);
    oct_vld     = v;
    frame_start = st;
    mode_sel    = 4'(m);
    @(posedge clk);
    #1;
    if (completes)
      for (int s = 0; s < 4; s++) begin
        hold_i[s] = ti[s];
        hold_q[s] = tq[s];
      end
    check_outputs(completes, tag);
  endtask

  // Reference packer: random samples for the slots the mode fills, zero
  // for the rest; random octets on every lane before placement.
  task automatic pack(int m);
    bit use_s [4];
    int slot_of [4];
    int n;
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 4; k++) lb[l][k] = 8'($urandom);
    for (int s = 0; s < 4; s++) use_s[s] = 0;
    case (m)
      0: begin use_s[0] = 1; use_s[1] = 1; end
      1, 3, 7: use_s[0] = 1;
      2, 4, 8: begin use_s[0] = 1; use_s[2] = 1; end
      5, 9, 11: begin use_s[0] = 1; use_s[1] = 1; end
      default: for (int s = 0; s < 4; s++) use_s[s] = 1;
    endcase
    for (int s = 0; s < 4; s++) begin
      ti[s] = use_s[s] ? 16'($urandom) : 16'h0;
      tq[s] = use_s[s] ? 16'($urandom) : 16'h0;
      if (m >= 11) begin ti[s] &= 16'hFFF0; tq[s] &= 16'hFFF0; end
    end
    if (m == 0) begin
      lb[0][0] = ti[0][15:8]; lb[1][0] = ti[0][7:0];
      lb[2][0] = ti[1][15:8]; lb[3][0] = ti[1][7:0];
      lb[4][0] = tq[0][15:8]; lb[5][0] = tq[0][7:0];
      lb[6][0] = tq[1][15:8]; lb[7][0] = tq[1][7:0];
    end else if (m <= 2) begin
      for (int d = 0; d < (m == 2 ? 2 : 1); d++) begin
        lb[4*d][0]   = ti[2*d][15:8]; lb[4*d+1][0] = ti[2*d][7:0];
        lb[4*d+2][0] = tq[2*d][15:8]; lb[4*d+3][0] = tq[2*d][7:0];
      end
    end else if (m <= 6) begin
      n = (m == 3) ? 1 : (m == 6) ? 4 : 2;
      for (int p = 0; p < n; p++) begin
        slot_of[p] = (m == 4) ? 2 * p : p;
        lb[2*p][0]   = ti[slot_of[p]][15:8]; lb[2*p][1]   = ti[slot_of[p]][7:0];
        lb[2*p+1][0] = tq[slot_of[p]][15:8]; lb[2*p+1][1] = tq[slot_of[p]][7:0];
      end
    end else if (m <= 10) begin
      n = (m == 7) ? 1 : (m == 10) ? 4 : 2;
      for (int l = 0; l < n; l++) begin
        slot_of[l] = (m == 8) ? 2 * l : l;
        lb[l][0] = ti[slot_of[l]][15:8]; lb[l][1] = ti[slot_of[l]][7:0];
        lb[l][2] = tq[slot_of[l]][15:8]; lb[l][3] = tq[slot_of[l]][7:0];
      end
    end else begin
      n = (m == 11) ? 2 : 4;
      for (int l = 0; l < n; l++) begin
        logic [23:0] w24;
        w24 = {ti[l][15:4], tq[l][15:4]};
        lb[l][0] = w24[23:16]; lb[l][1] = w24[15:8]; lb[l][2] = w24[7:0];
      end
    end
  endtask

  // Send one frame; optional idle gaps and mode noise off the start octet.
  task automatic send_frame(int m, bit gaps, bit noise);
    int f = flen(m);
    string tag = noise ? {mtag(m), " R10 R11"} : {mtag(m), " R10 R2"};
    pack(m);
    for (int k = 0; k < f; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        for (int l = 0; l < 8; l++) lane_oct[l] = 8'($urandom);
        step(0, ($urandom % 2) == 1 ? 1'b0 : 1'b0,
             noise ? int'($urandom % 13) : m, 0, "R2 gap");
      end
      for (int l = 0; l < 8; l++) lane_oct[l] = lb[l][k];
      step(1, k == 0, (k == 0 || !noise) ? m : int'($urandom % 13),
           k == f - 1, tag);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin hold_i[s] = 16'h0; hold_q[s] = 16'h0; end
    rst = 1'b1; oct_vld = 1'b0; frame_start = 1'b0; mode_sel = 4'd0;
    lane_oct = '0;
    repeat (3) @(posedge clk);
    #1;
    check_outputs(0, "R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // Valid octets before any frame start: nothing emitted.
    for (int c = 0; c < 6; c++) begin
      for (int l = 0; l < 8; l++) lane_oct[l] = 8'($urandom);
      step(1, 0, 0, 0, "R1 presync");
    end

    // Every mode, back-to-back, then with gaps and mode noise.
    for (int m = 0; m < 13; m++) begin
      for (int fr = 0; fr < 6; fr++) send_frame(m, 0, 0);
      for (int fr = 0; fr < 6; fr++) send_frame(m, 1, 1);
    end

    // Restart in mid frame: partial F=4 frame, then a full frame.
    for (int m = 3; m < 13; m++) begin
      pack(10);
      for (int l = 0; l < 8; l++) lane_oct[l] = lb[l][0];
      step(1, 1, 10, 0, "R12 partial");
      for (int l = 0; l < 8; l++) lane_oct[l] = lb[l][1];
      step(1, 0, 10, 0, "R12 partial");
      send_frame(m, 0, 0);
      send_frame(m, 1, 1);
    end

    // Idle cycles after the last frame: pulse gone, outputs held.
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 8; l++) lane_oct[l] = 8'($urandom);
      step(0, 0, int'($urandom % 13), 0, "R3 hold");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule